// File: doc/BRIEF.md
# Iterative Right-Shift Unsigned Multiplier

This block multiplies two unsigned N-bit operands over N clock cycles. One 2N-bit working register holds both the multiplier and the growing product. When the block starts, the multiplier goes into the low half of that register and the high half is cleared. The multiplicand is latched into a holding register at the same moment.

Each cycle of an operation shifts the working register right by one place. If the bit that falls out of position 0 is a one, an N-bit ripple adder adds the held multiplicand to the window that sits just under the top bit. The adder's carry is written into the most significant bit. After N such steps the register holds the full 2N-bit product, and a one-cycle completion pulse is raised.

A start request is accepted only while the block is idle. The product stays unchanged until the next accepted start. Reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `shift_add_mul`

## Requirements
- R1: While reset is asserted, and after it is released, the block is idle: busy=0, done=0 and product=0.
- R2: A start seen while busy=0 is accepted at that clock edge. From the next cycle busy=1 and product equals {N zeros, multiplier}.
- R3: Each step shifts the working register right by one. If the bit shifted out of bit 0 is 1, the latched multiplicand is added to bits [2N-2:N-1] and the (N+1)-bit sum, carry included, is written to bits [2N-1:N-1]. For N=4, multiplicand 1100 and multiplier 0101 give 0x62 after the first step.
- R4: An operation takes exactly N steps. busy stays 1 for exactly N cycles after the accepting edge.
- R5: done is a single-cycle pulse. It rises in the first cycle in which busy is 0 again.
- R6: In the done cycle, product equals multiplicand times multiplier as unsigned numbers. For N=4, 1100 x 0101 gives 00111100.
- R7: A start seen while busy=1 is ignored, and operand inputs that change during an operation do not affect its result or its timing.
- R8: While idle with no start, product holds its value.
- R9: All-ones operands give the largest product without loss through the carry path. For N=4 this is 1111 x 1111 = 11100001.

Parameter N (at least 2) sets the operand width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| mcand | input | N | Multiplicand, latched on an accepted start |
| mplier | input | N | Multiplier, loaded into the low half on an accepted start |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when the product is final |
| product | output | 2N | Working register; the final product from done until the next start |

## Verification
The bound checker checks these properties on every cycle:
- the load image after an accepted start;
- the busy length of N cycles, counted by its own counter;
- the done pulse coinciding with busy falling;
- the product matching the operands captured at the accepting edge;
- the product holding while idle.

Only the bench's scenarios show certain behaviours:
- the exact intermediate value after one shift-and-add step;
- that a start or operand change during an operation leaves the result alone;
- the all-ones carry case;
- behaviour across every 4-bit operand pair and random 16-bit operands.

// File: rtl/sam_pkg.sv
package sam_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sam_state_e;

  function automatic int unsigned sam_cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/sam_rst_sync.sv
module sam_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/sam_ctrl.sv
module sam_ctrl
  import sam_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);

  localparam int unsigned CW = sam_cnt_width(N);
  localparam logic [CW-1:0] LAST_STEP = CW'(N - 1);

  sam_state_e      state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            cnt_en;
  logic            done_q, done_d;
  logic            last;

  assign load = (state_q == ST_IDLE) && start;
  assign step = (state_q == ST_RUN);
  assign last = (cnt_q == LAST_STEP);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_RUN;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      ST_RUN: begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q + 1'b1;
        if (last) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = step;
  assign done = done_q;

endmodule

// File: rtl/sam_adder.sv
module sam_adder #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N:0]   sum
);

  logic [N:0] carry;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign sum[i]     = a[i] ^ b[i] ^ carry[i];
    assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
  end

  assign sum[N] = carry[N];

endmodule

// File: rtl/sam_datapath.sv
module sam_datapath #(
  parameter int unsigned N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  output logic [2*N-1:0] acc
);

  localparam int unsigned W = 2 * N;

  logic [W-1:0] acc_q, acc_d;
  logic         acc_en;
  logic [N-1:0] mc_q;
  logic         mc_en;
  logic [W-1:0] shifted;
  logic         out_bit;
  logic [N:0]   win_sum;

  assign shifted = acc_q >> 1;
  assign out_bit = acc_q[0];

  sam_adder #(.N(N)) u_adder (
    .a   (shifted[W-2:N-1]),
    .b   (mc_q),
    .sum (win_sum)
  );

  assign acc_en = load | step;
  assign mc_en  = load;

  always_comb begin
    acc_d = acc_q;
    if (load) begin
      acc_d = {{N{1'b0}}, mplier};
    end else if (step) begin
      if (out_bit) begin
        acc_d = {win_sum, shifted[N-2:0]};
      end else begin
        acc_d = shifted;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_q <= '0;
    end else if (mc_en) begin
      mc_q <= mcand;
    end
  end

  assign acc = acc_q;

endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int unsigned N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  output logic           busy,
  output logic           done,
  output logic [2*N-1:0] product
);

  logic rst_sync_n;
  logic load;
  logic step;

  sam_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  sam_ctrl #(.N(N)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .start (start),
    .load  (load),
    .step  (step),
    .busy  (busy),
    .done  (done)
  );

  sam_datapath #(.N(N)) u_dp (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load   (load),
    .step   (step),
    .mcand  (mcand),
    .mplier (mplier),
    .acc    (product)
  );

endmodule

// File: rtl/shift_add_mul_chk.sv
module shift_add_mul_chk #(
  parameter int unsigned N = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [N-1:0]   mcand,
  input logic [N-1:0]   mplier,
  input logic           busy,
  input logic           done,
  input logic [2*N-1:0] product
);

  localparam int unsigned CW = $clog2(N + 1) + 1;

  logic [2*N-1:0] ref_a, ref_b;
  logic [CW-1:0]  busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_a    <= '0;
      ref_b    <= '0;
      busy_cnt <= '0;
    end else if (start && !busy) begin
      ref_a    <= {{N{1'b0}}, mcand};
      ref_b    <= {{N{1'b0}}, mplier};
      busy_cnt <= '0;
    end else if (busy) begin
      busy_cnt <= busy_cnt + 1'b1;
    end
  end

  a_r2_load_image: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && product == {{N{1'b0}}, $past(mplier)}));

  a_r4_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_cnt < CW'(N)));

  a_r4_step_count: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == CW'(N)));

  a_r5_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_product: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (product == ref_a * ref_b));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));

endmodule

bind shift_add_mul shift_add_mul_chk #(.N(N)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .start   (start),
  .mcand   (mcand),
  .mplier  (mplier),
  .busy    (busy),
  .done    (done),
  .product (product)
);

// File: tb/test_shift_add_mul.sv
module test_shift_add_mul;

  localparam int unsigned NS = 4;
  localparam int unsigned NW = 16;
  localparam int unsigned WATCHDOG_CYCLES = 200000;

  // {multiplicand, multiplier, expected product} for NS = 4
  localparam logic [15:0] VEC [7] = '{
    16'hC53C, 16'hFFE1, 16'h0F00, 16'hF000,
    16'h1101, 16'h8840, 16'hB74D
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;

  logic            start;
  logic [NS-1:0]   mcand, mplier;
  logic            busy, done;
  logic [2*NS-1:0] product;

  logic            start_w;
  logic [NW-1:0]   mcand_w, mplier_w;
  logic            busy_w, done_w;
  logic [2*NW-1:0] product_w;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  shift_add_mul #(.N(NS)) i_shift_add_mul (
    .clk (clk), .rst_n (rst_n), .start (start), .mcand (mcand),
    .mplier (mplier), .busy (busy), .done (done), .product (product)
  );

  shift_add_mul #(.N(NW)) i_shift_add_mul_wide (
    .clk (clk), .rst_n (rst_n), .start (start_w), .mcand (mcand_w),
    .mplier (mplier_w), .busy (busy_w), .done (done_w), .product (product_w)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // Full operation on the 4-bit instance; inputs driven and outputs sampled at negedge.
  task automatic run4(input logic [NS-1:0] a, input logic [NS-1:0] b);
    logic [2*NS-1:0] exp;
    exp = {{NS{1'b0}}, a} * {{NS{1'b0}}, b};
    @(negedge clk);
    start = 1'b1; mcand = a; mplier = b;
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after start", 64'(busy), 64'd1);
    chk("R2 load image", 64'(product), 64'({{NS{1'b0}}, b}));
    repeat (NS - 1) @(negedge clk);
    chk("R4 still busy at step N-1", 64'({busy, done}), 64'b10);
    @(negedge clk);
    chk("R4/R5 done with busy low", 64'({busy, done}), 64'b01);
    chk("R6 product", 64'(product), 64'(exp));
    @(negedge clk);
    chk("R5 done one cycle", 64'(done), 64'd0);
    chk("R8 product held", 64'(product), 64'(exp));
  endtask

  task automatic run16(input logic [NW-1:0] a, input logic [NW-1:0] b);
    logic [2*NW-1:0] exp;
    exp = {{NW{1'b0}}, a} * {{NW{1'b0}}, b};
    @(negedge clk);
    start_w = 1'b1; mcand_w = a; mplier_w = b;
    @(negedge clk);
    start_w = 1'b0;
    repeat (NW) @(negedge clk);
    chk("R4 wide done timing", 64'({busy_w, done_w}), 64'b01);
    chk("R6 wide product", 64'(product_w), 64'(exp));
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    start = 1'b0; mcand = '0; mplier = '0;
    start_w = 1'b0; mcand_w = '0; mplier_w = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", 64'({busy, done, product}), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle after release", 64'({busy, done, product}), 64'd0);

    // Vector table
    for (int i = 0; i < 7; i++) begin
      run4(VEC[i][15:12], VEC[i][11:8]);
      chk("R6 table vector", 64'(product), 64'(VEC[i][7:0]));
    end

    // R3: first step of 1100 x 0101 gives 0x62; R9: first step of 1111 x 1111 gives 0x7F
    @(negedge clk);
    start = 1'b1; mcand = 4'b1100; mplier = 4'b0101;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R3 first step add with shift", 64'(product), 64'h62);
    repeat (NS) @(negedge clk);
    @(negedge clk);
    start = 1'b1; mcand = 4'b1111; mplier = 4'b1111;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R9 first step all ones", 64'(product), 64'h7F);
    repeat (NS - 1) @(negedge clk);
    chk("R9 all ones product", 64'({done, product}), 64'h1E1);

    // R7: start and operand changes during an operation are ignored
    @(negedge clk);
    start = 1'b1; mcand = 4'b1100; mplier = 4'b0101;
    @(negedge clk);
    mcand = 4'b1111; mplier = 4'b1111;
    repeat (NS - 1) @(negedge clk);
    chk("R7 busy unchanged by extra start", 64'({busy, done}), 64'b10);
    start = 1'b0;
    @(negedge clk);
    chk("R7 result from latched operands", 64'({done, product}), 64'h13C);

    // R8: idle inputs changing without start leave product alone
    mcand = 4'b0110; mplier = 4'b1001;
    repeat (4) @(negedge clk);
    chk("R8 idle hold", 64'({busy, product}), 64'h03C);

    // Exhaustive 4-bit sweep
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        run4(4'(a), 4'(b));
      end
    end

    // Wide instance: corners and random operands
    run16(16'hFFFF, 16'hFFFF);
    run16(16'h0000, 16'hFFFF);
    run16(16'h8000, 16'h0001);
    for (int k = 0; k < 60; k++) begin
      run16(16'($urandom), 16'($urandom));
    end

    // R1: reset in the middle of an operation
    @(negedge clk);
    start = 1'b1; mcand = 4'b1010; mplier = 4'b0111;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset mid-operation", 64'({busy, done, product}), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle after second release", 64'({busy, done, product}), 64'd0);

    finished = 1'b1;
    summary();
  end

endmodule